// File: doc/BRIEF.md
# Bit-Stuffing Frame Serializer

This block turns bytes into a bit-oriented framed serial stream on one data line. The line is marking (1) while the transmitter is off. Once enabled, the line carries back-to-back flag octets (01111110) whenever there is nothing to send. A byte is handed in through a one-deep holding buffer and is sent least-significant bit first. The block starts it on the first byte boundary after the flag octet in progress. Bytes written quickly enough follow each other with no flags between them. One bit leaves per pulse of the bit-rate enable strobe. In data, a 0 is stuffed after any five 1s in a row. Flag and abort patterns are never stuffed.

The byte input is a valid/ready port. `wr_ready` is high exactly when the holding buffer is empty. A byte is taken on a clock edge where `wr_valid` and `wr_ready` are both high. While `wr_ready` is low, `wr_valid` and `wr_data` are ignored and the producer must hold or retry. A one-cycle abort pulse discards the byte being shifted and the byte in the buffer, sends eight 1s and then returns to flags. Break forces the line low. An interrupt latch is set whenever a byte moves from the buffer into the shifter. A new write or a reset-pending pulse clears it. Underrun status is raised when a data byte ends with the buffer empty.

Top module: `sdlc_tx_framer`

## Requirements
- R1: After reset `txd`=1, `wr_ready`=1, `irq`=0 and `underrun`=0. While `tx_enable`=0 the line is held at 1 whatever strobes arrive, and on re-enable framing restarts at bit 0 of a flag.
- R2: While `brk`=1, `txd` is 0 from the next clock on. When `brk` is released, `txd` returns to the serializer's line value.
- R3: When enabled with no byte buffered, each strobe sends the next bit of the flag 01111110, in the order 0,1,1,1,1,1,1,0, back to back.
- R4: A buffered byte is sent LSB first. It starts with the strobe after the last bit of the current flag, or after the last bit of the previous byte, which gives back-to-back bytes.
- R5: In data, after five consecutive 1s one 0 is inserted before the next data bit, including across a byte boundary. The ones count restarts on every 0 sent, inserted zeros included.
- R6: Flag bits are never stuffed. The six 1s of a flag appear unbroken.
- R7: A one-cycle `abort_req` while enabled empties the buffer (`wr_ready`=1 on the next cycle) and drops the byte being shifted. The next eight strobes send 1 with no stuffing, and flags follow. Up to 13 ones may appear in a row.
- R8: `wr_ready` goes low on the cycle after a byte is accepted. It returns high on the cycle after the strobe edge that moves the byte into the shifter. A write while `wr_ready`=0 has no effect.
- R9: With `int_en`=1, `irq` rises on the cycle after a byte moves into the shifter. An accepted write or a `rst_pend` pulse clears it, and it stays low until another byte is moved. With `int_en`=0 the latch is not set.
- R10: `underrun` rises after a strobe ends a data byte with the buffer empty, and an accepted write clears it.
- R11: `txd` changes only on a clock edge with `bit_en`=1, or with `abort_req`, `tx_enable` or `brk` activity.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_en | input | 1 | Bit-rate strobe, one serial bit per pulse |
| wr_valid | input | 1 | Byte write request |
| wr_ready | output | 1 | Holding buffer empty, write accepted |
| wr_data | input | 8 | Byte to send |
| tx_enable | input | 1 | Transmitter enable |
| brk | input | 1 | Force the line to 0 |
| abort_req | input | 1 | One-cycle abort command |
| rst_pend | input | 1 | One-cycle clear of the interrupt latch |
| int_en | input | 1 | Allow the interrupt latch to set |
| txd | output | 1 | Serial data output |
| irq | output | 1 | Transmit-buffer-empty interrupt |
| underrun | output | 1 | Data ran out at a byte boundary |

## Verification
A scoreboard holds the expected bit stream built from the requirements. The serializer is driven with idle flags, with the alternating byte A5 that never triggers stuffing, and with FF and 7E, which each need one inserted zero. The pair F8 then 01 ends one byte on five 1s, so only a ones count carried across the boundary produces the right stream. An abort issued after five 1s of data tells a true 13-one run from one where stuffing leaks into the abort pattern. Writes against a full buffer, reset-pending without a write, and `int_en`=0 show whether the interrupt and ready logic follow the handover rather than the write.

// File: rtl/sdlc_tx_pkg.sv
package sdlc_tx_pkg;
  typedef enum logic [1:0] {
    ST_FLAG  = 2'd0,
    ST_DATA  = 2'd1,
    ST_ABORT = 2'd2
  } tx_state_e;
endpackage

// File: rtl/sdlc_tx_holdbuf.sv
module sdlc_tx_holdbuf #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_valid,
  input  logic [DW-1:0] wr_data,
  output logic          wr_ready,
  input  logic          take,
  input  logic          flush,
  input  logic          int_en,
  input  logic          rst_pend,
  input  logic          underrun_evt,
  output logic          full,
  output logic [DW-1:0] data,
  output logic          irq,
  output logic          underrun
);
  logic          full_q, pend_q, udr_q;
  logic [DW-1:0] data_q;
  logic          accept;

  assign accept   = wr_valid && !full_q;
  assign wr_ready = !full_q;
  assign full     = full_q;
  assign data     = data_q;
  assign irq      = pend_q;
  assign underrun = udr_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      full_q <= 1'b0;
      data_q <= '0;
      pend_q <= 1'b0;
      udr_q  <= 1'b0;
    end else begin
      if (accept) begin
        full_q <= 1'b1;
        data_q <= wr_data;
      end else if (take || flush) begin
        full_q <= 1'b0;
      end
      if (take && int_en)          pend_q <= 1'b1;
      else if (accept || rst_pend) pend_q <= 1'b0;
      if (accept)            udr_q <= 1'b0;
      else if (underrun_evt) udr_q <= 1'b1;
    end
  end

  // R8: a held byte survives until it is moved or flushed
  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    full_q && !take && !flush |=> full_q && $stable(data_q));
  // R9: a write or reset-pending clears the latch
  p_irq_clr_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (accept || rst_pend) && !take |=> !pend_q);
  // R9: handover with interrupts allowed sets the latch
  p_irq_set_r9: assert property (@(posedge clk) disable iff (!rst_n)
    take && int_en |=> pend_q);
  // R10: an accepted write clears underrun
  p_udr_clr_r10: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !udr_q);
endmodule

// File: rtl/sdlc_tx_bitgen.sv
module sdlc_tx_bitgen
  import sdlc_tx_pkg::*;
#(
  parameter int DW        = 8,
  parameter int MAX_ONES  = 5,
  parameter int ABORT_LEN = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          bit_en,
  input  logic          abort_req,
  input  logic          buf_full,
  input  logic [DW-1:0] buf_data,
  output logic          take,
  output logic          underrun_evt,
  output logic          line
);
  localparam int CW = $clog2(DW > ABORT_LEN ? DW : ABORT_LEN);
  localparam int OW = $clog2(MAX_ONES + 1);
  localparam logic [DW-1:0] FLAG_PAT = {1'b0, {(DW-2){1'b1}}, 1'b0};

  tx_state_e     state_q;
  logic [CW-1:0] cnt_q;
  logic [OW-1:0] ones_q;
  logic [DW-1:0] sh_q;
  logic          line_q;
  logic          last_bit, stuff, step, slot_end;

  always_comb begin
    last_bit     = (cnt_q == CW'(DW-1));
    stuff        = (ones_q == OW'(MAX_ONES));
    step         = en && bit_en && !abort_req;
    slot_end     = step && last_bit &&
                   ((state_q == ST_FLAG) || (state_q == ST_DATA && !stuff));
    take         = slot_end && buf_full;
    underrun_evt = slot_end && !buf_full && (state_q == ST_DATA);
  end

  assign line = line_q;

  always_ff @(posedge clk) begin
    if (!rst_n || !en) begin
      state_q <= ST_FLAG;
      cnt_q   <= '0;
      ones_q  <= '0;
      sh_q    <= '0;
      line_q  <= 1'b1;
    end else if (abort_req) begin
      state_q <= ST_ABORT;
      cnt_q   <= '0;
      ones_q  <= '0;
    end else if (bit_en) begin
      unique case (state_q)
        ST_FLAG: begin
          line_q <= FLAG_PAT[cnt_q];
          ones_q <= '0;
          if (last_bit) begin
            cnt_q <= '0;
            if (buf_full) begin
              sh_q    <= buf_data;
              state_q <= ST_DATA;
            end
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        ST_DATA: begin
          if (stuff) begin
            line_q <= 1'b0;
            ones_q <= '0;
          end else begin
            line_q <= sh_q[0];
            sh_q   <= {1'b0, sh_q[DW-1:1]};
            ones_q <= sh_q[0] ? ones_q + 1'b1 : '0;
            if (last_bit) begin
              cnt_q <= '0;
              if (buf_full) sh_q    <= buf_data;
              else          state_q <= ST_FLAG;
            end else begin
              cnt_q <= cnt_q + 1'b1;
            end
          end
        end
        default: begin
          line_q <= 1'b1;
          if (cnt_q == CW'(ABORT_LEN-1)) begin
            cnt_q   <= '0;
            state_q <= ST_FLAG;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
      endcase
    end
  end

  // R1: disabled means marking on the next cycle
  p_mark_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> line_q);
  // R11: no strobe, no change
  p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    en && !bit_en && !abort_req |=> $stable(line_q));
  // R5: the ones count never passes the stuffing limit
  p_ones_cap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ones_q <= OW'(MAX_ONES));
  // R5: the limit forces a zero on the next data strobe
  p_stuff_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    step && state_q == ST_DATA && stuff |=> !line_q);
  // R7: abort bits are all ones
  p_abort_ones_r7: assert property (@(posedge clk) disable iff (!rst_n)
    step && state_q == ST_ABORT |=> line_q);
endmodule

// File: rtl/sdlc_tx_framer.sv
module sdlc_tx_framer #(
  parameter int DW        = 8,
  parameter int MAX_ONES  = 5,
  parameter int ABORT_LEN = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bit_en,
  input  logic          wr_valid,
  output logic          wr_ready,
  input  logic [DW-1:0] wr_data,
  input  logic          tx_enable,
  input  logic          brk,
  input  logic          abort_req,
  input  logic          rst_pend,
  input  logic          int_en,
  output logic          txd,
  output logic          irq,
  output logic          underrun
);
  logic          take, udr_evt, buf_full, line;
  logic [DW-1:0] buf_data;

  sdlc_tx_holdbuf #(.DW(DW)) u_buf (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_data(wr_data),
    .wr_ready(wr_ready), .take(take), .flush(tx_enable && abort_req),
    .int_en(int_en), .rst_pend(rst_pend), .underrun_evt(udr_evt),
    .full(buf_full), .data(buf_data), .irq(irq), .underrun(underrun)
  );

  sdlc_tx_bitgen #(.DW(DW), .MAX_ONES(MAX_ONES), .ABORT_LEN(ABORT_LEN)) u_gen (
    .clk(clk), .rst_n(rst_n), .en(tx_enable), .bit_en(bit_en),
    .abort_req(abort_req), .buf_full(buf_full), .buf_data(buf_data),
    .take(take), .underrun_evt(udr_evt), .line(line)
  );

  assign txd = brk ? 1'b0 : line;

  // R8: a handover empties the buffer on the next cycle
  p_ready_back_r8: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> wr_ready);
endmodule

// File: tb/test_sdlc_tx_framer.sv
`timescale 1ns/1ps
module test_sdlc_tx_framer;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic       rst_n = 1'b0, bit_en = 1'b0, wr_valid = 1'b0, tx_enable = 1'b0;
  logic       brk = 1'b0, abort_req = 1'b0, rst_pend = 1'b0, int_en = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic       wr_ready, txd, irq, underrun;

  sdlc_tx_framer i_sdlc_tx_framer (
    .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .wr_valid(wr_valid),
    .wr_ready(wr_ready), .wr_data(wr_data), .tx_enable(tx_enable), .brk(brk),
    .abort_req(abort_req), .rst_pend(rst_pend), .int_en(int_en),
    .txd(txd), .irq(irq), .underrun(underrun)
  );

  int    n_cmp = 0, n_bad = 0, ones = 0;
  logic  exp_q[$];
  string cur_req = "R1";
  logic  samp = 1'b0;
  localparam logic [7:0] FLAG = 8'h7E;

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // monitor: compare each serial bit after its strobe edge
  always @(posedge clk) samp <= bit_en;
  always @(negedge clk) begin
    if (samp) begin
      if (exp_q.size() == 0) check({cur_req, " extra bit"}, 32'(txd), 32'hx);
      else check(cur_req, 32'(txd), 32'(exp_q.pop_front()));
    end
  end

  task automatic push_flag();
    for (int i = 0; i < 8; i++) exp_q.push_back(FLAG[i]);
    ones = 0;
  endtask
  task automatic push_byte(logic [7:0] b);
    for (int i = 0; i < 8; i++) begin
      if (ones == 5) begin exp_q.push_back(1'b0); ones = 0; end
      exp_q.push_back(b[i]);
      ones = b[i] ? ones + 1 : 0;
    end
  endtask
  task automatic push_ones(int n);
    for (int i = 0; i < n; i++) exp_q.push_back(1'b1);
  endtask
  task automatic tick();
    @(negedge clk) bit_en = 1'b1;
    @(negedge clk) bit_en = 1'b0;
    repeat (2) @(negedge clk);
  endtask
  task automatic drain();
    while (exp_q.size() != 0) tick();
  endtask
  task automatic wr(logic [7:0] b);
    @(negedge clk) begin wr_valid = 1'b1; wr_data = b; end
    @(negedge clk) wr_valid = 1'b0;
  endtask
  task automatic pulse_rst_pend();
    @(negedge clk) rst_pend = 1'b1;
    @(negedge clk) rst_pend = 1'b0;
  endtask
  task automatic pulse_abort();
    @(negedge clk) abort_req = 1'b1;
    @(negedge clk) abort_req = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic t0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 txd", 32'(txd), 1);
    check("R1 wr_ready", 32'(wr_ready), 1);
    check("R1 irq", 32'(irq), 0);
    check("R1 underrun", 32'(underrun), 0);
    cur_req = "R1 disabled strobes"; push_ones(3); drain();

    tx_enable = 1'b1; int_en = 1'b1;
    cur_req = "R3 idle flags"; push_flag(); push_flag(); drain();

    wr(8'hA5);
    check("R8 ready low after write", 32'(wr_ready), 0);
    wr(8'h00); // R8: ignored while full
    cur_req = "R4 flag before byte"; push_flag(); drain();
    check("R8 ready after handover", 32'(wr_ready), 1);
    check("R9 irq on handover", 32'(irq), 1);
    wr(8'hFF);
    check("R9 irq cleared by write", 32'(irq), 0);
    cur_req = "R4 byte A5 LSB first"; push_byte(8'hA5); drain();
    check("R9 irq on second handover", 32'(irq), 1);
    pulse_rst_pend();
    check("R9 irq cleared by rst_pend", 32'(irq), 0);
    cur_req = "R5 FF stuffing"; push_byte(8'hFF); drain();
    check("R10 underrun set", 32'(underrun), 1);
    cur_req = "R6 flag no stuffing"; push_flag(); drain();
    check("R9 no irq without write", 32'(irq), 0);

    wr(8'hF8);
    check("R10 underrun cleared", 32'(underrun), 0);
    cur_req = "R4 flag"; push_flag(); drain();
    wr(8'h01);
    cur_req = "R5 stuffing across bytes"; push_byte(8'hF8); push_byte(8'h01); drain();
    wr(8'h7E);
    cur_req = "R6 flag after data"; push_flag(); drain();
    cur_req = "R5 data 7E stuffed"; push_byte(8'h7E); push_flag(); drain();

    wr(8'hFF);
    cur_req = "R4 flag"; push_flag(); drain();
    wr(8'h55);
    check("R7 buffer full before abort", 32'(wr_ready), 0);
    cur_req = "R7 data before abort"; push_ones(5); drain();
    pulse_abort();
    check("R7 buffer discarded", 32'(wr_ready), 1);
    cur_req = "R7 abort ones then flags"; push_ones(8); push_flag(); push_flag(); drain();

    cur_req = "R11 flag"; push_flag(); tick();
    t0 = txd;
    repeat (3) @(negedge clk);
    check("R11 stable between strobes", 32'(txd), 32'(t0));
    tick();
    check("R2 line high before break", 32'(txd), 1);
    @(negedge clk) brk = 1'b1;
    @(negedge clk);
    check("R2 break forces 0", 32'(txd), 0);
    brk = 1'b0;
    @(negedge clk);
    check("R2 released", 32'(txd), 1);
    drain();

    @(negedge clk) tx_enable = 1'b0;
    @(negedge clk);
    check("R1 disable marks", 32'(txd), 1);
    cur_req = "R1 disabled strobes"; push_ones(2); drain();

    tx_enable = 1'b1; int_en = 1'b0;
    wr(8'h81);
    cur_req = "R1 restart on flag"; push_flag(); drain();
    check("R9 no irq when disabled", 32'(irq), 0);
    cur_req = "R4 byte 81"; push_byte(8'h81); push_flag(); drain();

    check("R4 scoreboard empty", 32'(exp_q.size()), 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule